// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Hub

This block holds one 32-bit control and status word for each of up to 32 DMA channels. It sits between a 32-bit register bus and the channel engines that move the data. Software writes a channel word to start or stop that channel, to acknowledge events and to set or clear the compare flag. The hub turns those writes into one-cycle run and descriptor-fetch strobes for the engine. The engines report start, end, end-of-receive, bus-error and stopped events, and the hub latches each of them into the matching channel word.

Each channel word feeds five interrupt sources. The stop, end-of-receive and request-after-stop sources count only when their own enable bit is set. The start and end sources count whenever their flag is set. The per-channel result is gathered into a read-only summary register, and a single interrupt line is high while any summary bit is set. The hub also holds a free 32-bit alignment register and a programmed-I/O control register.

The bus front end is a three-state sequencer. `BUS_IDLE` accepts a request. The transition IDLE→DONE is taken for a legal access and IDLE→FAULT for an illegal one. `BUS_DONE` and `BUS_FAULT` each present the response for one cycle, and both always return to `BUS_IDLE`.

Top module: `dma_status_hub`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stop flag, bit 3, set). The alignment, programmed-I/O and summary registers read 0. `irq` is low and `req_ready` is high.
- R2: A write to a channel word clears bits 0, 1, 2 and 9 wherever the written value has a 1. It keeps bits 3, 4 and 10, except where R3 to R5 change them. It replaces bits 23 and 26 to 31 with the written value. Bits 22, 24 and 25 are strobes and always read 0.
- R3: A write with bit 31 (run) set clears the stop flag. In the cycle after acceptance it pulses `cmd_run[c]`. If bit 30 (no-descriptor-fetch) is clear, it also pulses `cmd_fetch[c]` in that cycle.
- R4: A write with both bit 31 and bit 22 (mask-run) clear sets the stop flag. Otherwise, a written bit 29 (stop interrupt enable) clears the stop flag.
- R5: A written bit 24 clears the compare flag (bit 10), and a written bit 25 sets it. When both are written, the compare flag ends up set.
- R6: In a channel word read, bit 8 shows the live level of `chan_req[c]`.
- R7: Engine events set flags as follows: `ev_start` sets bit 1, `ev_end` sets bit 2, `ev_eor` sets bit 9, `ev_buserr` sets bit 0. `ev_stop` sets bit 3 and clears bit 31. A rising `chan_req[c]` while bit 3 is set sets bit 4, and a falling `chan_req[c]` clears bit 4.
- R8: Summary bit c is (b29&b3)|(b28&b9)|(b23&b4)|b1|b2 of channel word c. `irq` is high exactly when the summary is nonzero, and a bus error flag alone raises nothing.
- R9: The alignment register keeps all 32 written bits. The programmed-I/O register keeps only bits 31 and 0.
- R10: Channel c sits at byte offset 4·c. The alignment register is at 0xA0, the programmed-I/O register at 0xA4 and the summary at 0xF0 (read-only).
- R11: The following accesses get `rsp_err` with read data 0 and change no register: a size code other than 2 (word), an address with bits 1:0 nonzero, an unmapped offset, or a write to the summary.
- R12: A request is accepted while `req_ready` is high. The response (`rsp_valid`) lasts exactly one cycle after acceptance, and `req_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Access size code, 2 = 32-bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data, 0 on error or write |
| chan_req | input | NUM_CH | Live request level per channel |
| ev_buserr | input | NUM_CH | Engine bus-error event |
| ev_start | input | NUM_CH | Engine descriptor-start event |
| ev_end | input | NUM_CH | Engine transfer-end event |
| ev_eor | input | NUM_CH | Engine end-of-receive event |
| ev_stop | input | NUM_CH | Engine stopped event |
| cmd_run | output | NUM_CH | One-cycle run strobe |
| cmd_fetch | output | NUM_CH | One-cycle descriptor-fetch strobe |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that a channel engine does not report `ev_stop` in the same cycle that a run write to that channel is accepted. The run-clears-stop property excludes that cycle explicitly. The assertions also assume the bus presents one request at a time and never expects a response while the sequencer is not idle. The stimulus raises engine events only in cycles with no register write to the same channel. It starts every access on the falling edge after the previous response has retired, and it holds every `chan_req` low through reset, so no request-after-stop flag appears out of reset.

// File: rtl/dsh_pkg.sv
package dsh_pkg;

    // Status word bit positions.
    localparam int B_BUSERR  = 0;
    localparam int B_START   = 1;
    localparam int B_END     = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQ     = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MASKRUN = 22;
    localparam int B_RASEN   = 23;
    localparam int B_CMPCLR  = 24;
    localparam int B_CMPSET  = 25;
    localparam int B_EOREN   = 28;
    localparam int B_STOPEN  = 29;
    localparam int B_NODESC  = 30;
    localparam int B_RUN     = 31;

    localparam logic [31:0] HOLD_MASK  = 32'h0000_071F;
    localparam logic [31:0] ACK_MASK   = 32'h0000_0207;
    localparam logic [31:0] LOAD_MASK  = 32'hFC80_0000;
    localparam logic [31:0] PIO_MASK   = 32'h8000_0001;
    localparam logic [31:0] CHAN_RESET = 32'h0000_0008;

    localparam int OFS_ALIGN   = 'hA0;
    localparam int OFS_PIO     = 'hA4;
    localparam int OFS_SUMMARY = 'hF0;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_DONE,
        BUS_FAULT
    } bus_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ALIGN,
        SEL_PIO,
        SEL_SUMMARY
    } reg_sel_t;

    // Effect of a software write on a stored channel word.
    function automatic logic [31:0] apply_write(input logic [31:0] cur,
                                                input logic [31:0] v);
        logic [31:0] r;
        r = cur & HOLD_MASK & ~(v & ACK_MASK);
        r = r | (v & LOAD_MASK);
        if (r[B_STOPEN])
            r[B_STOP] = 1'b0;
        if (v[B_RUN])
            r[B_STOP] = 1'b0;
        if (!v[B_RUN] && !v[B_MASKRUN])
            r[B_STOP] = 1'b1;
        if (v[B_CMPCLR])
            r[B_CMP] = 1'b0;
        if (v[B_CMPSET])
            r[B_CMP] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dsh_decode.sv
module dsh_decode
    import dsh_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 12,
    parameter int CH_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    output reg_sel_t          sel,
    output logic [CH_W-1:0]   ch
);
    localparam logic [ADDR_W-1:0] STAT_END = ADDR_W'(4 * NUM_CH);
    localparam logic [ADDR_W-1:0] A_ALIGN  = ADDR_W'(OFS_ALIGN);
    localparam logic [ADDR_W-1:0] A_PIO    = ADDR_W'(OFS_PIO);
    localparam logic [ADDR_W-1:0] A_SUM    = ADDR_W'(OFS_SUMMARY);

    always_comb begin
        sel = SEL_NONE;
        ch  = addr[CH_W+1:2];
        if (size == SIZE_WORD && addr[1:0] == 2'b00) begin
            if (addr < STAT_END)
                sel = SEL_STATUS;
            else if (addr == A_ALIGN)
                sel = SEL_ALIGN;
            else if (addr == A_PIO)
                sel = SEL_PIO;
            else if (addr == A_SUM && !write)
                sel = SEL_SUMMARY;
        end
    end
endmodule

// File: rtl/dsh_chan_reg.sv
module dsh_chan_reg
    import dsh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        req_lvl,
    input  logic        ev_buserr,
    input  logic        ev_start,
    input  logic        ev_end,
    input  logic        ev_eor,
    input  logic        ev_stop,
    output logic [31:0] word,
    output logic        cmd_run,
    output logic        cmd_fetch
);
    logic        req_prev;
    logic [31:0] word_nxt;

    // Software write first, engine events layered on top.
    always_comb begin
        word_nxt = wr_en ? apply_write(word, wdata) : word;
        if (ev_buserr)
            word_nxt[B_BUSERR] = 1'b1;
        if (ev_start)
            word_nxt[B_START] = 1'b1;
        if (ev_end)
            word_nxt[B_END] = 1'b1;
        if (ev_eor)
            word_nxt[B_EOR] = 1'b1;
        if (ev_stop) begin
            word_nxt[B_STOP] = 1'b1;
            word_nxt[B_RUN]  = 1'b0;
        end
        if (req_lvl && !req_prev && word[B_STOP])
            word_nxt[B_RAS] = 1'b1;
        if (!req_lvl && req_prev)
            word_nxt[B_RAS] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word      <= CHAN_RESET;
            req_prev  <= 1'b0;
            cmd_run   <= 1'b0;
            cmd_fetch <= 1'b0;
        end else begin
            word      <= word_nxt;
            req_prev  <= req_lvl;
            cmd_run   <= wr_en && wdata[B_RUN];
            cmd_fetch <= wr_en && wdata[B_RUN] && !wdata[B_NODESC];
        end
    end
endmodule

// File: rtl/dsh_irq_merge.sv
module dsh_irq_merge #(
    parameter int NUM_CH = 32
) (
    input  logic [NUM_CH-1:0] stop_f,
    input  logic [NUM_CH-1:0] stop_en,
    input  logic [NUM_CH-1:0] eor_f,
    input  logic [NUM_CH-1:0] eor_en,
    input  logic [NUM_CH-1:0] ras_f,
    input  logic [NUM_CH-1:0] ras_en,
    input  logic [NUM_CH-1:0] start_f,
    input  logic [NUM_CH-1:0] end_f,
    output logic [31:0]       summary,
    output logic              irq
);
    logic [NUM_CH-1:0] vec_stop;
    logic [NUM_CH-1:0] vec_eor;
    logic [NUM_CH-1:0] vec_ras;
    logic [NUM_CH-1:0] vec_start;
    logic [NUM_CH-1:0] vec_end;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_vec
        assign vec_stop[c]  = stop_f[c] & stop_en[c];
        assign vec_eor[c]   = eor_f[c] & eor_en[c];
        assign vec_ras[c]   = ras_f[c] & ras_en[c];
        assign vec_start[c] = start_f[c];
        assign vec_end[c]   = end_f[c];
    end

    assign summary = 32'(vec_stop | vec_eor | vec_ras | vec_start | vec_end);
    assign irq     = |summary;
endmodule

// File: rtl/dma_status_hub.sv
module dma_status_hub
    import dsh_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] ev_eor,
    input  logic [NUM_CH-1:0] ev_stop,
    output logic [NUM_CH-1:0] cmd_run,
    output logic [NUM_CH-1:0] cmd_fetch,
    output logic              irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    bus_state_t        state_q, state_d;
    reg_sel_t          dec_sel;
    logic [CH_W-1:0]   dec_ch;
    logic              accept;
    logic              wr_go;
    logic [31:0]       rd_val;
    logic [31:0]       align_q;
    logic [31:0]       pio_q;
    logic [31:0]       sum_vec;
    logic [31:0]       chan_word [NUM_CH];
    logic [NUM_CH-1:0] stop_f, stop_en, eor_f, eor_en;
    logic [NUM_CH-1:0] ras_f, ras_en, start_f, end_f;

    dsh_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_dec (
        .addr  (req_addr),
        .size  (req_size),
        .write (req_write),
        .sel   (dec_sel),
        .ch    (dec_ch)
    );

    assign accept = req_valid && (state_q == BUS_IDLE);
    assign wr_go  = accept && req_write;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dsh_chan_reg u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_go && dec_sel == SEL_STATUS && dec_ch == CH_W'(c)),
            .wdata     (req_wdata),
            .req_lvl   (chan_req[c]),
            .ev_buserr (ev_buserr[c]),
            .ev_start  (ev_start[c]),
            .ev_end    (ev_end[c]),
            .ev_eor    (ev_eor[c]),
            .ev_stop   (ev_stop[c]),
            .word      (chan_word[c]),
            .cmd_run   (cmd_run[c]),
            .cmd_fetch (cmd_fetch[c])
        );
        assign stop_f[c]  = chan_word[c][B_STOP];
        assign stop_en[c] = chan_word[c][B_STOPEN];
        assign eor_f[c]   = chan_word[c][B_EOR];
        assign eor_en[c]  = chan_word[c][B_EOREN];
        assign ras_f[c]   = chan_word[c][B_RAS];
        assign ras_en[c]  = chan_word[c][B_RASEN];
        assign start_f[c] = chan_word[c][B_START];
        assign end_f[c]   = chan_word[c][B_END];
    end

    dsh_irq_merge #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .stop_f  (stop_f),
        .stop_en (stop_en),
        .eor_f   (eor_f),
        .eor_en  (eor_en),
        .ras_f   (ras_f),
        .ras_en  (ras_en),
        .start_f (start_f),
        .end_f   (end_f),
        .summary (sum_vec),
        .irq     (irq)
    );

    // Read multiplexer.
    always_comb begin
        unique case (dec_sel)
            SEL_STATUS:  rd_val = chan_word[dec_ch] | (32'(chan_req[dec_ch]) << B_REQ);
            SEL_ALIGN:   rd_val = align_q;
            SEL_PIO:     rd_val = pio_q;
            SEL_SUMMARY: rd_val = sum_vec;
            default:     rd_val = 32'h0;
        endcase
    end

    // Sequencer: next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (req_valid)
                           state_d = (dec_sel == SEL_NONE) ? BUS_FAULT : BUS_DONE;
            BUS_DONE:  state_d = BUS_IDLE;
            BUS_FAULT: state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // Sequencer: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BUS_IDLE;
        else
            state_q <= state_d;
    end

    // Sequencer: outputs.
    assign req_ready = (state_q == BUS_IDLE);
    assign rsp_valid = (state_q != BUS_IDLE);
    assign rsp_err   = (state_q == BUS_FAULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsp_rdata <= 32'h0;
        else if (accept)
            rsp_rdata <= (req_write || dec_sel == SEL_NONE) ? 32'h0 : rd_val;
    end

    // Shared configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_q <= 32'h0;
            pio_q   <= 32'h0;
        end else if (wr_go) begin
            if (dec_sel == SEL_ALIGN)
                align_q <= req_wdata;
            if (dec_sel == SEL_PIO)
                pio_q <= req_wdata & PIO_MASK;
        end
    end
endmodule

// File: rtl/dma_status_hub_chk.sv
module dma_status_hub_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              req_ready,
    input logic [NUM_CH-1:0] cmd_run,
    input logic [NUM_CH-1:0] cmd_fetch,
    input logic [NUM_CH-1:0] ev_stop,
    input logic [NUM_CH-1:0] stop_f,
    input logic [NUM_CH-1:0] start_f,
    input logic [31:0]       sum_vec,
    input logic              irq,
    input logic [31:0]       align_q,
    input logic [31:0]       pio_q
);
    a_r3_fetch_with_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fetch & ~cmd_run) == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        a_r3_run_clears_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_run[i] && !$past(ev_stop[i])) |-> !stop_f[i]);
        a_r8_start_ungated: assert property (@(posedge clk) disable iff (!rst_n)
            start_f[i] |-> sum_vec[i]);
    end

    a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_vec != 32'h0) |-> irq);
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_vec == 32'h0) |-> !irq);
    a_r11_err_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (align_q == $past(align_q) && pio_q == $past(pio_q)));
    a_r12_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r12_busy_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

bind dma_status_hub dma_status_hub_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .req_ready (req_ready),
    .cmd_run   (cmd_run),
    .cmd_fetch (cmd_fetch),
    .ev_stop   (ev_stop),
    .stop_f    (stop_f),
    .start_f   (start_f),
    .sum_vec   (sum_vec),
    .irq       (irq),
    .align_q   (align_q),
    .pio_q     (pio_q)
);

// File: tb/dma_status_hub_test.sv
`timescale 1ns/1ps
module dma_status_hub_test;
    localparam int NCH = 32;
    localparam int AW  = 12;

    typedef struct packed {
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    // Write d to a, read a back, expect e. Each status entry uses a fresh channel (R2, R4, R5, R9, R10).
    localparam vec_t TBL [0:12] = '{
        '{12'h000, 32'h0000_0000, 32'h0000_0008},
        '{12'h004, 32'h8000_0000, 32'h8000_0000},
        '{12'h008, 32'hC040_0000, 32'hC000_0000},
        '{12'h00C, 32'h2040_0000, 32'h2000_0000},
        '{12'h010, 32'h0200_0000, 32'h0000_0408},
        '{12'h014, 32'h0300_0000, 32'h0000_0408},
        '{12'h018, 32'h1C80_0000, 32'h1C80_0008},
        '{12'h01C, 32'h0000_FFFF, 32'h0000_0008},
        '{12'h020, 32'hFFFF_FFFF, 32'hFC80_0400},
        '{12'h07C, 32'h0440_0000, 32'h0400_0008},
        '{12'h0A0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{12'h0A4, 32'hFFFF_FFFF, 32'h8000_0001},
        '{12'h0A4, 32'h1234_5678, 32'h0000_0000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = 2'd2;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid, rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NCH-1:0]  chan_req = '0;
    logic [NCH-1:0]  ev_buserr = '0, ev_start = '0, ev_end = '0, ev_eor = '0, ev_stop = '0;
    logic [NCH-1:0]  cmd_run, cmd_fetch;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic            g_valid, g_err, g_ready;
    logic [31:0]     g_data;
    logic [NCH-1:0]  g_run, g_fetch;

    always #2.5 clk = ~clk;

    dma_status_hub #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .chan_req(chan_req), .ev_buserr(ev_buserr), .ev_start(ev_start),
        .ev_end(ev_end), .ev_eor(ev_eor), .ev_stop(ev_stop),
        .cmd_run(cmd_run), .cmd_fetch(cmd_fetch), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        g_valid = rsp_valid; g_err = rsp_err; g_data = rsp_rdata;
        g_ready = req_ready; g_run = cmd_run; g_fetch = cmd_fetch;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        access(1'b1, a, 2'd2, d);
    endtask

    task automatic rd32(input logic [11:0] a);
        access(1'b0, a, 2'd2, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 req_ready", 32'(req_ready), 32'h1);
        chk("R12 no response idle", 32'(rsp_valid), 32'h0);
        rd32(12'h000); chk("R1 ch0 word", g_data, 32'h8);
        chk("R12 rsp_valid", 32'(g_valid), 32'h1);
        chk("R12 busy during rsp", 32'(g_ready), 32'h0);
        @(negedge clk);
        chk("R12 rsp ends", 32'(rsp_valid), 32'h0);
        chk("R12 ready again", 32'(req_ready), 32'h1);
        rd32(12'h044); chk("R1 ch17 word", g_data, 32'h8);
        rd32(12'h0A0); chk("R1 align", g_data, 32'h0);
        rd32(12'h0A4); chk("R1 pio", g_data, 32'h0);
        rd32(12'h0F0); chk("R1 summary", g_data, 32'h0);

        // Table walk
        for (int i = 0; i <= 12; i++) begin
            wr32(TBL[i].a, TBL[i].d);
            chk($sformatf("R10 table %0d write ok", i), 32'(g_err), 32'h0);
            rd32(TBL[i].a);
            chk($sformatf("R2/R9 table %0d readback", i), g_data, TBL[i].e);
        end
        rd32(12'h0F0); chk("R8 summary after table", g_data, 32'h0);
        chk("R8 irq after table", 32'(irq), 32'h0);

        // R3 command strobes
        wr32(12'h028, 32'h8000_0000);
        chk("R3 run strobe ch10", g_run, 32'h0000_0400);
        chk("R3 fetch strobe ch10", g_fetch, 32'h0000_0400);
        @(negedge clk);
        chk("R3 strobe one cycle", cmd_run, 32'h0);
        wr32(12'h02C, 32'hC000_0000);
        chk("R3 run strobe ch11", g_run, 32'h0000_0800);
        chk("R3 no fetch in nodesc", g_fetch, 32'h0);

        // R5 compare clear
        wr32(12'h050, 32'h0200_0000); rd32(12'h050); chk("R5 cmp set", g_data, 32'h408);
        wr32(12'h050, 32'h0100_0000); rd32(12'h050); chk("R5 cmp clear", g_data, 32'h8);

        // R7/R8 start event, ungated
        @(negedge clk); ev_start[12] = 1'b1; @(negedge clk); ev_start[12] = 1'b0;
        rd32(12'h030); chk("R7 start flag", g_data, 32'h0000_000A);
        rd32(12'h0F0); chk("R8 start in summary", g_data, 32'h0000_1000);
        chk("R8 irq from start", 32'(irq), 32'h1);
        wr32(12'h030, 32'h0000_0002); rd32(12'h030); chk("R2 start ack", g_data, 32'h8);
        chk("R8 irq cleared", 32'(irq), 32'h0);

        // End event
        @(negedge clk); ev_end[13] = 1'b1; @(negedge clk); ev_end[13] = 1'b0;
        rd32(12'h034); chk("R7 end flag", g_data, 32'h0000_000C);
        chk("R8 irq from end", 32'(irq), 32'h1);
        wr32(12'h034, 32'h0000_0004); rd32(12'h034); chk("R2 end ack", g_data, 32'h8);

        // End-of-receive, gated by bit 28
        @(negedge clk); ev_eor[14] = 1'b1; @(negedge clk); ev_eor[14] = 1'b0;
        rd32(12'h038); chk("R7 eor flag", g_data, 32'h0000_0208);
        rd32(12'h0F0); chk("R8 eor gated off", g_data, 32'h0);
        wr32(12'h038, 32'h1000_0000); rd32(12'h0F0); chk("R8 eor enabled", g_data, 32'h0000_4000);
        wr32(12'h038, 32'h0000_0200); rd32(12'h038); chk("R2 eor ack", g_data, 32'h8);

        // Stop source, gated by bit 29
        wr32(12'h03C, 32'h2040_0000); rd32(12'h03C); chk("R4 stopen clears stop", g_data, 32'h2000_0000);
        @(negedge clk); ev_stop[15] = 1'b1; @(negedge clk); ev_stop[15] = 1'b0;
        rd32(12'h0F0); chk("R8 stop in summary", g_data, 32'h0000_8000);
        wr32(12'h03C, 32'h0); rd32(12'h0F0); chk("R8 stop disabled", g_data, 32'h0);

        // Stop event clears run
        wr32(12'h040, 32'h8000_0000);
        @(negedge clk); ev_stop[16] = 1'b1; @(negedge clk); ev_stop[16] = 1'b0;
        rd32(12'h040); chk("R7 stop event clears run", g_data, 32'h8);

        // Bus error raises no interrupt
        @(negedge clk); ev_buserr[17] = 1'b1; @(negedge clk); ev_buserr[17] = 1'b0;
        rd32(12'h044); chk("R7 buserr flag", g_data, 32'h9);
        chk("R8 buserr no irq", 32'(irq), 32'h0);
        wr32(12'h044, 32'h1); rd32(12'h044); chk("R2 buserr ack", g_data, 32'h8);

        // Request-after-stop and live request bit
        @(negedge clk); chan_req[18] = 1'b1;
        rd32(12'h048); chk("R6/R7 ras flag and req", g_data, 32'h0000_0118);
        rd32(12'h0F0); chk("R8 ras gated off", g_data, 32'h0);
        wr32(12'h048, 32'h0080_0000); rd32(12'h048); chk("R2 ras kept", g_data, 32'h0080_0118);
        rd32(12'h0F0); chk("R8 ras enabled", g_data, 32'h0004_0000);
        @(negedge clk); chan_req[18] = 1'b0;
        rd32(12'h048); chk("R7 ras cleared on fall", g_data, 32'h0080_0008);
        chk("R8 ras irq gone", 32'(irq), 32'h0);
        wr32(12'h04C, 32'hC080_0000);
        @(negedge clk); chan_req[19] = 1'b1;
        rd32(12'h04C); chk("R7 no ras while running", g_data, 32'hC080_0100);
        @(negedge clk); chan_req[19] = 1'b0;

        // R11 error responses
        access(1'b0, 12'h0A0, 2'd1, 32'h0);
        chk("R11 half read err", 32'(g_err), 32'h1);
        chk("R11 err data zero", g_data, 32'h0);
        access(1'b1, 12'h0A0, 2'd0, 32'h0);
        chk("R11 byte write err", 32'(g_err), 32'h1);
        rd32(12'h0A0); chk("R11 align untouched", g_data, 32'hDEAD_BEEF);
        wr32(12'h0F0, 32'hFFFF_FFFF); chk("R11 summary write err", 32'(g_err), 32'h1);
        rd32(12'h080); chk("R11 unmapped err", 32'(g_err), 32'h1);
        rd32(12'h0A2); chk("R11 misaligned err", 32'(g_err), 32'h1);
        wr32(12'h0A5, 32'hFFFF_FFFF); chk("R11 misaligned write err", 32'(g_err), 32'h1);
        rd32(12'h0A4); chk("R11 pio untouched", g_data, 32'h0);
        chk("R11 good read no err", 32'(g_err), 32'h0);

        finish_run();
    end
endmodule